// File: doc/BRIEF.md
# Five-Input Prioritized Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core. It has five request lines. One line cannot be masked and is accepted only on a fresh rising edge. Three lines are vectored and can each be masked. One of them is captured by an edge latch, and the other two act while their level is high. The last line is a general request whose vector is supplied from outside the block. The block holds a global enable flag, three mask bits and the edge latch. It presents the highest-priority live request together with its fixed entry address.

The core talks to the block through a one-cycle write strobe with an 8-bit control byte and a combinational 8-bit status byte. The control byte can load the masks, cancel a captured edge and drive a serial output pin. The status byte returns the enable flag, the masks, the raw pending lines and a registered copy of the serial input pin. Enable and disable commands arrive as single-cycle pulses. When the core takes the presented request it raises `ack_i`. This clears the global enable and consumes whichever edge record belonged to the winning source. `irq_o` also tells a halted core to resume.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset the three mask bits are 1, the global enable is 0, the edge latch is clear, `sout_o` is 0 and `irq_o` is low, so the status byte reads 0x07 while `sin_i` is low.
- R2: `en_cmd_i` sets the global enable and `dis_cmd_i` clears it, with disable winning when both arrive together. While the enable is 0, no source other than the non-maskable line can raise `irq_o`.
- R3: A write with control bit 3 set loads control bits 2:0 into the masks. Bit 2 masks the edge-latched line, bit 1 masks `rq_hi_i` and bit 0 masks `rq_lo_i`, and a 1 blocks that line. A write with bit 3 clear leaves the masks unchanged.
- R4: A rising edge on `rq_edge_i` sets the edge latch, which stays set after the line falls. `rq_hi_i` and `rq_lo_i` count as pending only while they are high.
- R5: A write with control bit 4 set clears the edge latch. If a new rising edge on `rq_edge_i` arrives in the same cycle, the latch ends up set.
- R6: `irq_o` shows the winner of the fixed order non-maskable > edge line > `rq_hi_i` > `rq_lo_i` > `ext_rq_i`. `vec_o` is 0x24 for the non-maskable line, 0x3C for the edge line, 0x34 for `rq_hi_i` and 0x2C for `rq_lo_i`.
- R7: When `ext_rq_i` wins, `vec_ext_o` is 1 and `vec_o` is 0. Otherwise `vec_ext_o` is 0.
- R8: `ack_i` taken while `irq_o` is high clears the global enable. If the edge line won, the ack also clears the edge latch.
- R9: `trap_i` raises a request regardless of enable and masks, but only after a rising edge and only while it is still high. Once that request is acknowledged, a line held high raises no new request until it falls and rises again.
- R10: A write with control bit 6 set loads control bit 7 into `sout_o`. A write with bit 6 clear leaves `sout_o` unchanged.
- R11: The status byte is {sampled `sin_i`, edge latch, `rq_hi_i`, `rq_lo_i`, global enable, masks[2:0]}, from bit 7 down to bit 0. Bit 7 follows `sin_i` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | Non-maskable request, edge-armed and level-held |
| rq_edge_i | input | 1 | Maskable request captured on its rising edge |
| rq_hi_i | input | 1 | Maskable level request, higher rank |
| rq_lo_i | input | 1 | Maskable level request, lower rank |
| ext_rq_i | input | 1 | General request with an externally supplied vector |
| en_cmd_i | input | 1 | Pulse: set global enable |
| dis_cmd_i | input | 1 | Pulse: clear global enable |
| set_we_i | input | 1 | Control byte write strobe |
| set_data_i | input | 8 | Control byte |
| rd_data_o | output | 8 | Status byte |
| sin_i | input | 1 | Serial input pin |
| sout_o | output | 1 | Serial output pin |
| ack_i | input | 1 | Core takes the presented request |
| irq_o | output | 1 | Request to the core, also wakes it from halt |
| vec_o | output | ADDR_W | Entry address of the winner |
| vec_ext_o | output | 1 | Winner is the externally vectored line |

## Verification
Two pairs of events can land in the same cycle. The first is a software clear of the edge latch together with a new rising edge on that line. The bench holds the line low for one cycle and then raises it in the very cycle of a clear write, and it expects the status byte to still show the latch set. The second pair is an enable pulse and a disable pulse issued together. The bench expects the enable bit to read back 0.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   localparam int NUM_SRC  = 5;
   localparam int NUM_VEC  = 4;
   localparam int IDX_TRAP = 0;
   localparam int IDX_EDGE = 1;
   localparam int IDX_HI   = 2;
   localparam int IDX_LO   = 3;
   localparam int IDX_EXT  = 4;

   localparam int CB_MASK_LO = 0;
   localparam int CB_MASK_EN = 3;
   localparam int CB_CLR_LAT = 4;
   localparam int CB_SO_EN   = 6;
   localparam int CB_SO_DAT  = 7;

   // Entry addresses are on an 8-byte grid; half-slot * 4 gives the byte address.
   function automatic int half_slot(int idx);
      case (idx)
         IDX_TRAP: return 9;
         IDX_EDGE: return 15;
         IDX_HI:   return 13;
         IDX_LO:   return 11;
         default:  return 0;
      endcase
   endfunction

endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic clr_i,
   output logic flag_o
);

   logic prev_q;
   logic flag_q;
   logic rise;

   assign rise   = lvl_i & ~prev_q;
   assign flag_o = flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (rise)  flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk) begin
            if (!rst_n)     flag_q <= 1'b0;
            else if (clr_i) flag_q <= 1'b0;
            else if (rise)  flag_q <= 1'b1;
         end
      end
   endgenerate

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_i) |=> flag_q); // R4

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] win_o,
   output logic         any_o
);

   logic [N:0] blocked;

   assign blocked[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign win_o[i]     = req_i[i] & ~blocked[i];
         assign blocked[i+1] = blocked[i] | req_i[i];
      end
   endgenerate

   assign any_o = blocked[N];

   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_o)); // R6

   AST_ANY_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> (win_o != '0)); // R6

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
   parameter int ADDR_W        = 16,
   parameter bit EDGE_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trap_i,
   input  logic              rq_edge_i,
   input  logic              rq_hi_i,
   input  logic              rq_lo_i,
   input  logic              ext_rq_i,
   input  logic              en_cmd_i,
   input  logic              dis_cmd_i,
   input  logic              set_we_i,
   input  logic [7:0]        set_data_i,
   output logic [7:0]        rd_data_o,
   input  logic              sin_i,
   output logic              sout_o,
   input  logic              ack_i,
   output logic              irq_o,
   output logic [ADDR_W-1:0] vec_o,
   output logic              vec_ext_o
);
   import irq_prio_pkg::*;

   localparam int MASK_W = 3;
   localparam logic [ADDR_W-1:0] TRAP_ADDR = ADDR_W'(half_slot(IDX_TRAP) * 4);

   generate
      if (ADDR_W < 6) begin : g_bad_addr_w
         $error("irq_prio_ctl: ADDR_W too small for vector grid");
      end
   endgenerate

   logic              ie_q;
   logic [MASK_W-1:0] mask_q;
   logic              sout_q;
   logic              sin_q;
   logic              lat_edge;
   logic              trap_arm;
   logic              trap_pend;
   logic              take;
   logic              clr_edge;
   logic              clr_trap;
   logic [NUM_SRC-1:0] req;
   logic [NUM_SRC-1:0] win;
   logic              any_req;
   logic [ADDR_W-1:0] vec_d;
   logic              unused_bits;

   assign unused_bits = set_data_i[5];

   assign take     = ack_i & any_req;
   assign clr_edge = (set_we_i & set_data_i[CB_CLR_LAT]) | (take & win[IDX_EDGE]);
   assign clr_trap = take & win[IDX_TRAP];

   irq_edge_cap #(.SET_WINS(EDGE_SET_WINS)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(rq_edge_i), .clr_i(clr_edge), .flag_o(lat_edge));

   irq_edge_cap #(.SET_WINS(1'b1)) u_trap (
      .clk(clk), .rst_n(rst_n), .lvl_i(trap_i), .clr_i(clr_trap), .flag_o(trap_arm));

   assign trap_pend = trap_arm & trap_i;

   assign req[IDX_TRAP] = trap_pend;
   assign req[IDX_EDGE] = lat_edge & ~mask_q[2] & ie_q;
   assign req[IDX_HI]   = rq_hi_i  & ~mask_q[1] & ie_q;
   assign req[IDX_LO]   = rq_lo_i  & ~mask_q[0] & ie_q;
   assign req[IDX_EXT]  = ext_rq_i & ie_q;

   irq_arbiter #(.N(NUM_SRC)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(req), .win_o(win), .any_o(any_req));

   always_comb begin
      vec_d = '0;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (win[i]) vec_d = vec_d | ADDR_W'(half_slot(i) * 4);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         mask_q <= '1;
         sout_q <= 1'b0;
         sin_q  <= 1'b0;
      end else begin
         sin_q <= sin_i;
         if (take || dis_cmd_i) ie_q <= 1'b0;
         else if (en_cmd_i)     ie_q <= 1'b1;
         if (set_we_i && set_data_i[CB_MASK_EN])
            mask_q <= set_data_i[CB_MASK_LO +: MASK_W];
         if (set_we_i && set_data_i[CB_SO_EN])
            sout_q <= set_data_i[CB_SO_DAT];
      end
   end

   assign irq_o     = any_req;
   assign vec_o     = vec_d;
   assign vec_ext_o = win[IDX_EXT];
   assign sout_o    = sout_q;
   assign rd_data_o = {sin_q, lat_edge, rq_hi_i, rq_lo_i, ie_q, mask_q};

   AST_TRAP_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pend |-> (irq_o && vec_o == TRAP_ADDR)); // R9

   AST_GATED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_q && !trap_pend) |-> !irq_o); // R2

   AST_ACK_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> !ie_q); // R8

   AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we_i && !set_data_i[CB_MASK_EN]) |=> $stable(mask_q)); // R3

   AST_EXT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      vec_ext_o |-> (vec_o == '0)); // R7

endmodule

// File: tb/sim_irq_prio_ctl.sv
module sim_irq_prio_ctl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        trap_i, rq_edge_i, rq_hi_i, rq_lo_i, ext_rq_i;
   logic        en_cmd_i, dis_cmd_i, set_we_i, sin_i, ack_i;
   logic [7:0]  set_data_i;
   logic [7:0]  rd_data_o;
   logic        sout_o, irq_o, vec_ext_o;
   logic [15:0] vec_o;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   irq_prio_ctl u0 (
      .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rq_edge_i(rq_edge_i),
      .rq_hi_i(rq_hi_i), .rq_lo_i(rq_lo_i), .ext_rq_i(ext_rq_i),
      .en_cmd_i(en_cmd_i), .dis_cmd_i(dis_cmd_i), .set_we_i(set_we_i),
      .set_data_i(set_data_i), .rd_data_o(rd_data_o), .sin_i(sin_i),
      .sout_o(sout_o), .ack_i(ack_i), .irq_o(irq_o), .vec_o(vec_o),
      .vec_ext_o(vec_ext_o));

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      {trap_i, rq_edge_i, rq_hi_i, rq_lo_i, ext_rq_i} = '0;
      {en_cmd_i, dis_cmd_i, set_we_i, sin_i, ack_i} = '0;
      set_data_i = 8'h00;
      cyc(); cyc();
      rst_n = 1'b1;
      cyc();
   endtask

   task automatic wr(logic [7:0] d);
      set_we_i = 1'b1; set_data_i = d;
      cyc();
      set_we_i = 1'b0; set_data_i = 8'h00;
   endtask

   task automatic enable();
      en_cmd_i = 1'b1; cyc(); en_cmd_i = 1'b0;
   endtask

   task automatic take();
      ack_i = 1'b1; cyc(); ack_i = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 status", 16'(rd_data_o), 16'h07);
      chk("R1 irq", 16'(irq_o), 16'h0);
      chk("R1 sout", 16'(sout_o), 16'h0);
   endtask

   task automatic t_enable_mask();
      do_reset();
      rq_hi_i = 1'b1;
      enable();
      chk("R3 masked hi no irq", 16'(irq_o), 16'h0);
      chk("R2 enable readback", 16'(rd_data_o), 16'h2F);
      wr(8'h07);
      chk("R3 write without bit3 ignored", 16'(rd_data_o), 16'h2F);
      wr(8'h08);
      chk("R3 masks cleared", 16'(rd_data_o), 16'h28);
      chk("R6 hi vector", vec_o, 16'h0034);
      chk("R6 hi irq", 16'(irq_o), 16'h1);
      dis_cmd_i = 1'b1; cyc(); dis_cmd_i = 1'b0;
      chk("R2 disable blocks", 16'(irq_o), 16'h0);
      en_cmd_i = 1'b1; dis_cmd_i = 1'b1; cyc();
      en_cmd_i = 1'b0; dis_cmd_i = 1'b0;
      chk("R2 disable wins tie", 16'(rd_data_o[3]), 16'h0);
      enable();
      wr(8'h0D);
      rq_lo_i = 1'b1; cyc();
      chk("R3 per-line mask hi open", vec_o, 16'h0034);
      rq_hi_i = 1'b0; cyc();
      chk("R3 per-line mask lo blocked", 16'(irq_o), 16'h0);
   endtask

   task automatic t_priority();
      do_reset();
      wr(8'h08);
      enable();
      rq_hi_i = 1'b1; rq_lo_i = 1'b1; ext_rq_i = 1'b1; cyc();
      chk("R6 hi over lo and ext", vec_o, 16'h0034);
      chk("R7 ext flag low", 16'(vec_ext_o), 16'h0);
      rq_hi_i = 1'b0; cyc();
      chk("R6 lo over ext", vec_o, 16'h002C);
      rq_lo_i = 1'b0; cyc();
      chk("R7 ext flag", 16'(vec_ext_o), 16'h1);
      chk("R7 ext vector zero", vec_o, 16'h0000);
      chk("R7 ext irq", 16'(irq_o), 16'h1);
      trap_i = 1'b1; cyc();
      chk("R6 trap over ext", vec_o, 16'h0024);
   endtask

   task automatic t_edge_accept();
      do_reset();
      wr(8'h08);
      enable();
      rq_edge_i = 1'b1; cyc();
      rq_edge_i = 1'b0; rq_hi_i = 1'b1; cyc();
      chk("R4 latch holds after fall", 16'(rd_data_o[6]), 16'h1);
      chk("R6 edge over hi", vec_o, 16'h003C);
      take();
      chk("R8 ack clears latch and enable", 16'(rd_data_o), 16'h20);
      chk("R8 no irq after ack", 16'(irq_o), 16'h0);
   endtask

   task automatic t_clear_latch();
      do_reset();
      rq_edge_i = 1'b1; cyc();
      rq_edge_i = 1'b0; cyc();
      chk("R4 pending while masked", 16'(rd_data_o), 16'h47);
      wr(8'h10);
      chk("R5 clear write", 16'(rd_data_o), 16'h07);
      rq_edge_i = 1'b1;
      wr(8'h10);
      chk("R5 new edge beats clear", 16'(rd_data_o), 16'h47);
      wr(8'h10);
      chk("R4 level alone does not relatch", 16'(rd_data_o), 16'h07);
   endtask

   task automatic t_trap();
      do_reset();
      trap_i = 1'b1; cyc();
      chk("R9 trap ignores enable and masks", 16'(irq_o), 16'h1);
      chk("R9 trap vector", vec_o, 16'h0024);
      take();
      cyc();
      chk("R9 stuck high no repeat", 16'(irq_o), 16'h0);
      trap_i = 1'b0; cyc();
      trap_i = 1'b1; cyc();
      chk("R9 new edge re-arms", 16'(irq_o), 16'h1);
   endtask

   task automatic t_serial();
      do_reset();
      wr(8'hC0);
      chk("R10 sout load", 16'(sout_o), 16'h1);
      wr(8'h00);
      chk("R10 sout hold without bit6", 16'(sout_o), 16'h1);
      wr(8'h40);
      chk("R10 sout clear", 16'(sout_o), 16'h0);
      sin_i = 1'b1; #0;
      chk("R11 sin not yet sampled", 16'(rd_data_o[7]), 16'h0);
      cyc();
      chk("R11 sin sampled", 16'(rd_data_o), 16'h87);
   endtask

   initial begin
      t_reset();
      t_enable_mask();
      t_priority();
      t_edge_accept();
      t_clear_latch();
      t_trap();
      t_serial();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #80000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule